// File: doc/BRIEF.md
# LSB-First Serial Register Access Port

This block is a synchronous serial slave. A host uses it to read and write a 256-location byte space, which holds registers and message storage. A frame opens when chip select goes low and closes when chip select goes high. Within a frame, every byte travels least-significant bit first. The first byte is always the start address and every later byte is data. A separate direction pin selects the direction of the whole frame. When it is high, the block streams read data out on its serial output. When it is low, it turns the data bytes into write strobes towards the register file.

All four serial inputs are brought into the system clock domain through a two-stage synchroniser, and the serial clock edges are detected in that domain. The serial clock idles high. The host changes SDI after each falling edge and the block samples SDI on each rising edge. The block changes its serial output on each falling edge, so the host can sample it on the next rising edge. Each serial-clock half period must last at least six system clock cycles.

The address advances by one after every data byte and wraps around. In read frames, the block fetches each byte ahead of time. A fetch starts as soon as the previous byte has completed, so the LSB of the next byte is ready on the first falling edge of that byte.

Top module: `lsb_serial_port`

## Requirements
- R1: While chip select (`cs_ni`) is high, `sdo_oe_o` is 0, serial clock edges are ignored and neither `wr_en_o` nor `rd_req_o` is raised. A later frame starts cleanly with its address byte.
- R2: SDI is sampled on rising SCLK edges. SDO changes only on falling SCLK edges. The first bit of every byte, in either direction, is bit 0 and the eighth is bit 7.
- R3: The first complete byte of a frame is taken as the start address. Only the bytes after it are data.
- R4: With `rnw_i` = 0, `sdo_oe_o` is 0. Each complete data byte produces exactly one single-cycle `wr_en_o` pulse, carrying that byte on `wr_data_o` and its address on `wr_addr_o`.
- R5: With `rnw_i` = 1 and chip select low, `sdo_oe_o` is 1. Data byte k of the frame (k = 0, 1, …) carries the register content at start address + k.
- R6: The address increases by one after each data byte and wraps from FFh to 00h within a frame.
- R7: A read frame with n data bytes issues n+1 single-cycle `rd_req_o` pulses. The first follows the address byte. Each of the others follows a data byte and names the next address. `rd_data_i` is sampled in the cycle after the one in which `rd_req_o` is high.
- R8: If chip select rises in the middle of a byte, that partial byte is discarded. The bit count restarts, so the next frame's first byte is again an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in, LSB first |
| rnw_i | input | 1 | Direction: 1 = read, 0 = write |
| rd_data_i | input | DATA_W | Register file read data, valid the cycle after `rd_req_o` |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| wr_en_o | output | 1 | Write strobe, one cycle per data byte |
| wr_addr_o | output | DATA_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| rd_req_o | output | 1 | Read request, one cycle |
| rd_addr_o | output | DATA_W | Read address |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a two-stage synchroniser. It runs the serial clock at eight system cycles per half period, which leaves room for the synchroniser delay and the read prefetch before each falling edge. With an 8-bit address, a three-byte frame starting at FEh crosses the wrap to 00h. The bench runs that crossing in both directions. It also drives a frame whose chip select rises four bits into a byte, and then reads the affected locations back through the port.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lsp_edge.sv
module lsp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic active_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = active_i &  sclk_i & ~sclk_q;
  assign fall_o = active_i & ~sclk_i &  sclk_q;
endmodule

// File: rtl/lsp_rx.sv
module lsp_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;
  logic              last;

  assign sh_nxt = {sdi_i, sh_q[DATA_W-1:1]};
  assign last   = (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_i) begin
        cnt_q <= '0;  // partial byte dropped
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (last) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          byte_o <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
  import lsp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rnw_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [DATA_W-1:0] rd_addr_o
);
  phase_e            phase_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] addr_inc;

  assign addr_inc = addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_ADDR;
      addr_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_en_o  <= 1'b0;
      rd_req_o <= 1'b0;
      if (!active_i) begin
        phase_q <= PH_ADDR;
      end else if (done_i) begin
        if (phase_q == PH_ADDR) begin
          phase_q <= PH_DATA;
          addr_q  <= byte_i;
          if (rnw_i) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= byte_i;
          end
        end else begin
          addr_q <= addr_inc;
          if (rnw_i) begin
            rd_req_o  <= 1'b1;  // prefetch next byte
            rd_addr_o <= addr_inc;
          end else begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= byte_i;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsp_tx.sv
module lsp_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              load_q;
  logic [DATA_W-1:0] tx_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      tx_q   <= '0;
      idx_q  <= '0;
      sdo_o  <= 1'b0;
    end else if (!active_i) begin
      load_q <= 1'b0;
      idx_q  <= '0;
      sdo_o  <= 1'b0;
    end else begin
      load_q <= rd_req_i;
      if (load_q) begin
        tx_q  <= rd_data_i;
        idx_q <= '0;
      end else if (fall_i) begin
        sdo_o <= tx_q[idx_q];
        idx_q <= (idx_q == IDX_W'(DATA_W - 1)) ? '0 : idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsb_serial_port.sv
module lsb_serial_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              rnw_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [DATA_W-1:0] rd_addr_o
);
  localparam int unsigned NSIG = 4;

  logic [NSIG-1:0]   sync_q;
  logic              cs_s, sclk_s, sdi_s, rnw_s, active;
  logic              rise, fall, done, sdo_q;
  logic [DATA_W-1:0] rx_byte;

  // order {rnw, sdi, sclk, cs}; cs and sclk reset to idle high
  lsp_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({rnw_i, sdi_i, sclk_i, cs_ni}),
    .q_o (sync_q)
  );

  assign {rnw_s, sdi_s, sclk_s, cs_s} = sync_q;
  assign active = ~cs_s;

  lsp_edge u_edge (
    .clk_i, .rst_ni,
    .sclk_i   (sclk_s),
    .active_i (active),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  lsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .active_i (active),
    .rise_i   (rise),
    .sdi_i    (sdi_s),
    .done_o   (done),
    .byte_o   (rx_byte)
  );

  lsp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .active_i  (active),
    .rnw_i     (rnw_s),
    .done_i    (done),
    .byte_i    (rx_byte),
    .wr_en_o,
    .wr_addr_o,
    .wr_data_o,
    .rd_req_o,
    .rd_addr_o
  );

  lsp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .active_i  (active),
    .fall_i    (fall),
    .rd_req_i  (rd_req_o),
    .rd_data_i,
    .sdo_o     (sdo_q)
  );

  assign sdo_oe_o = active & rnw_s;
  assign sdo_o    = sdo_oe_o & sdo_q;
endmodule

// File: rtl/lsp_checker.sv
module lsp_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdo_oe_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_addr_o,
  input logic              rd_req_o
);
  logic [2:0]        quiet_q;
  logic              seen_q;
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            quiet_q <= '0;
    else if (!cs_ni)        quiet_q <= '0;
    else if (quiet_q != 3'd7) quiet_q <= quiet_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (cs_ni) begin
      seen_q <= 1'b0;
    end else if (wr_en_o) begin
      seen_q <= 1'b1;
      last_q <= wr_addr_o;
    end
  end

  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q >= 3'd4) |-> (!wr_en_o && !rd_req_o && !sdo_oe_o));

  assert_wr_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  assert_rd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  assert_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !wr_en_o);

  assert_incr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && seen_q && !cs_ni) |-> (wr_addr_o == DATA_W'(last_q + 1'b1)));
endmodule

bind lsb_serial_port lsp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sdo_oe_o  (sdo_oe_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .rd_req_o  (rd_req_o)
);

// File: tb/lsb_serial_port_tb.sv
module lsb_serial_port_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_ni, cs_n, sclk, sdi, rnw;
  logic [7:0] rd_data;
  logic       sdo, sdo_oe, wr_en, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr;

  always #10 clk = ~clk;

  lsb_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .rnw_i(rnw), .rd_data_i(rd_data), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr)
  );

  int checks = 0, fails = 0, rd_cnt = 0, stab = 0, cyc = 0;
  logic cs_prev = 1'b1, rnw_prev = 1'b0;
  logic [7:0] regf [256];
  logic [7:0] model [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [15:0] exp_q [$];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // register file stand-in
  always @(posedge clk) begin
    if (wr_en) regf[wr_addr] <= wr_data;
    if (rd_req) rd_data <= regf[rd_addr];
  end

  // input stability tracker for the per-clock enable model
  always @(posedge clk) begin
    if (cs_n != cs_prev || rnw != rnw_prev) stab = 0;
    else if (stab < 100) stab++;
    cs_prev = cs_n;
    rnw_prev = rnw;
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (stab >= 4) check(sdo_oe == (!cs_prev && rnw_prev), "R5/R4 oe", sdo_oe, !cs_prev && rnw_prev);
      if (rd_req) rd_cnt++;
      if (wr_en) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected strobe", {wr_addr, wr_data}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R4/R6 strobe", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic do_bits(input logic [7:0] b, input int nb, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      sdi = b[i];
      repeat (HALF) @(negedge clk);
      got[i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic frame(input logic rw, input logic [7:0] a, input int n);
    logic [7:0] g, ad;
    int rc0;
    rnw = rw;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    rc0 = rd_cnt;
    do_bits(a, 8, g);
    ad = a;
    for (int j = 0; j < n; j++) begin
      if (!rw) begin
        exp_q.push_back({ad, wbuf[j]});
        model[ad] = wbuf[j];
      end
      do_bits(rw ? 8'h00 : wbuf[j], 8, g);
      rbuf[j] = g;
      if (rw) check(g == model[ad], "R5/R2 read byte", g, model[ad]);
      ad++;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (rw) check(rd_cnt - rc0 == n + 1, "R7 request count", rd_cnt - rc0, n + 1);
    check(exp_q.size() == 0, "R4 strobes outstanding", exp_q.size(), 0);
  endtask

  initial begin
    logic [7:0] g;
    int rc0;
    rst_ni = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0; rnw = 1'b0;
    for (int i = 0; i < 256; i++) begin
      regf[i] = 8'(i * 37 + 11);
      model[i] = 8'(i * 37 + 11);
    end
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!sdo_oe && !wr_en && !rd_req, "R1 reset state", {sdo_oe, wr_en, rd_req}, 0);

    // R2/R3/R4: asymmetric bytes expose bit order; first byte is the address
    wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'hA6;
    frame(1'b0, 8'h10, 3);
    frame(1'b1, 8'h10, 3);
    check(rbuf[0] == 8'h01 && rbuf[1] == 8'h80, "R2 lsb first", {rbuf[0], rbuf[1]}, 16'h0180);
    wbuf[0] = 8'h5C;
    frame(1'b0, 8'h20, 1);
    frame(1'b1, 8'h20, 1);
    check(rbuf[0] == 8'h5C, "R3 address byte then data", rbuf[0], 8'h5C);

    // R5: read of untouched locations
    frame(1'b1, 8'h33, 4);

    // R6: wrap in both directions
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
    frame(1'b0, 8'hFE, 3);
    frame(1'b1, 8'hFF, 2);
    check(rbuf[1] == 8'hE3, "R6 read wrap to 00", rbuf[1], 8'hE3);

    // R1: clocks with chip select high are ignored
    rc0 = rd_cnt;
    rnw = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b0; sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      check(!sdo_oe, "R1 oe while deselected", sdo_oe, 0);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    check(rd_cnt == rc0, "R1 no requests while deselected", rd_cnt - rc0, 0);
    wbuf[0] = 8'h3E;
    frame(1'b0, 8'h60, 1);
    frame(1'b1, 8'h60, 1);
    check(rbuf[0] == 8'h3E, "R1 frame after idle clocks", rbuf[0], 8'h3E);

    // R8: chip select rises four bits into the second data byte
    rnw = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    do_bits(8'h40, 8, g);
    exp_q.push_back({8'h40, 8'hC3});
    model[8'h40] = 8'hC3;
    do_bits(8'hC3, 8, g);
    do_bits(8'hFF, 4, g);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R8 partial byte not written", exp_q.size(), 0);
    wbuf[0] = 8'h77;
    frame(1'b0, 8'h50, 1);
    frame(1'b1, 8'h40, 2);
    check(rbuf[1] == model[8'h41], "R8 location after abort unchanged", rbuf[1], model[8'h41]);
    frame(1'b1, 8'h50, 1);
    check(rbuf[0] == 8'h77, "R8 next frame starts with address", rbuf[0], 8'h77);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule